// File: doc/BRIEF.md
# SDRAM Mode Register Set Sequencer

This block issues the command sequence that programs an SDRAM device's mode register and then its extended mode register. A single register-write strobe starts it. The strobe carries a channel number and two data words: one for the base mode register and one for the extended mode register. The sequencer latches all three on the strobe. It then runs a fixed six-cycle sequence on the addressed channel only.

The sequence has two setting phases of three clock cycles each, and the length is not adjustable. The first phase loads the base mode register: a load-mode command carrying the base value on the address bus with bank select 00, then two deselect cycles. The second phase loads the extended mode register in the same way, using the extended value and bank select 01. The block shows a busy flag while the sequence runs, pulses a done flag once when it ends, and holds deselect on every output while idle. A write that arrives while the sequencer is busy has no effect.

Top module: `mrs_seq_top`

## Requirements
- R1: While idle, every chip select is high (inactive), ras_n, cas_n and we_n are all high, addr and bank are zero, and busy is low.
- R2: When wr_stb is high and busy is low at a clock edge, the next cycle shows busy high and the load-mode command (ras_n, cas_n and we_n all low). In that cycle cs_n of the addressed channel is low, addr equals the latched mode_val and bank equals 00.
- R3: In the two cycles after each load-mode command, the outputs show deselect: every cs_n is high and ras_n, cas_n and we_n are high.
- R4: The fourth cycle of the sequence issues the load-mode command again. In that cycle addr equals the latched ext_val and bank equals 01. Two deselect cycles follow it.
- R5: No cs_n bit other than the one for the latched channel (bit wr_ch of cs_n) is ever low, and at most one cs_n bit is low in any cycle.
- R6: busy stays high for exactly six cycles per sequence.
- R7: done is high for exactly one cycle: the cycle right after the sixth sequence cycle. In that cycle busy is low.
- R8: A wr_stb that arrives while busy is high is ignored. The running sequence keeps its channel, its data and its timing.
- R9: A wr_stb in the cycle where done is high is accepted, so a new sequence starts in the next cycle with no gap.
- R10: Changes on wr_ch, mode_val or ext_val after the accepting edge do not change the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Register-write strobe that starts a sequence |
| wr_ch | input | CH_W | Target channel of the write |
| mode_val | input | ADDR_W | Value for the base mode register |
| ext_val | input | ADDR_W | Value for the extended mode register |
| cs_n | output | NUM_CH | Chip select per channel, active low |
| ras_n | output | 1 | Row strobe command line, active low |
| cas_n | output | 1 | Column strobe command line, active low |
| we_n | output | 1 | Write enable command line, active low |
| addr | output | ADDR_W | Address bus carrying the register value |
| bank | output | BANK_W | Bank select: 00 for the base register, 01 for the extended register |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
A step counter that is off by one moves the second load-mode command away from the fourth cycle, or makes busy run longer or shorter than six cycles. Either error shows at the ports within one sequence. A latched channel or data value that is overwritten by a late strobe shows up in the next command cycle as a wrong chip select bit or a wrong address value. A missing or doubled done pulse shows one cycle after busy falls. For these reasons the bench checks every port in every cycle of each sequence. It also drives random strobes and random data while the sequencer is busy.

// File: rtl/mrs_seq_pkg.sv
package mrs_seq_pkg;

   localparam int unsigned SET_LEN   = 3;
   localparam int unsigned SET_COUNT = 2;
   localparam int unsigned STEPS     = SET_LEN * SET_COUNT;
   localparam int unsigned STEP_W    = $clog2(STEPS);

   typedef struct packed {
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sdr_cmd_t;

   localparam sdr_cmd_t CMD_DESELECT  = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam sdr_cmd_t CMD_LOAD_MODE = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

   typedef enum logic {
      SET_BASE = 1'b0,
      SET_EXT  = 1'b1
   } set_kind_e;

endpackage

// File: rtl/mrs_step_ctr.sv
module mrs_step_ctr
   import mrs_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic [STEP_W-1:0] step,
   output logic              done
);

   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (step == LAST_STEP) begin
               busy <= 1'b0;
               step <= '0;
               done <= 1'b1;
            end else begin
               step <= step + 1'b1;
            end
         end else if (start) begin
            busy <= 1'b1;
            step <= '0;
         end
      end
   end

   // R6: the step index never leaves the six-cycle window
   p_step_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (step <= LAST_STEP));

   // R7: done lasts one cycle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: done follows the end of busy
   p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R2: an accepted start begins at step zero
   p_start_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && step == '0));

endmodule

// File: rtl/mrs_cmd_decode.sv
module mrs_cmd_decode
   import mrs_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned BANK_W = 2
) (
   input  logic              busy,
   input  logic [STEP_W-1:0] step,
   input  logic [ADDR_W-1:0] mode_q,
   input  logic [ADDR_W-1:0] ext_q,
   output logic              issue,
   output sdr_cmd_t          cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank
);

   localparam logic [STEP_W-1:0] EXT_FIRST = STEP_W'(SET_LEN);

   set_kind_e         kind;
   logic [STEP_W-1:0] offset;

   always_comb begin
      kind   = (step >= EXT_FIRST) ? SET_EXT : SET_BASE;
      offset = (kind == SET_EXT) ? (step - EXT_FIRST) : step;
      issue  = busy && (offset == '0);
      cmd    = issue ? CMD_LOAD_MODE : CMD_DESELECT;
      addr   = '0;
      bank   = '0;
      if (issue) begin
         addr = (kind == SET_EXT) ? ext_q : mode_q;
         bank = BANK_W'(kind == SET_EXT);
      end
   end

endmodule

// File: rtl/mrs_cs_gen.sv
module mrs_cs_gen #(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned CH_W        = 2,
   parameter bit          SHIFT_DECODE = 1'b0
) (
   input  logic              issue,
   input  logic [CH_W-1:0]   ch,
   output logic [NUM_CH-1:0] cs_n
);

   if (SHIFT_DECODE) begin : g_shift
      logic [NUM_CH-1:0] sel;
      assign sel  = issue ? (NUM_CH'(1) << ch) : '0;
      assign cs_n = ~sel;
   end else begin : g_compare
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         assign cs_n[i] = ~(issue && (ch == CH_W'(i)));
      end
   end

endmodule

// File: rtl/mrs_seq_top.sv
module mrs_seq_top
   import mrs_seq_pkg::*;
#(
   parameter int unsigned NUM_CH       = 4,
   parameter int unsigned ADDR_W       = 13,
   parameter int unsigned BANK_W       = 2,
   parameter bit          SHIFT_DECODE = 1'b0,
   localparam int unsigned CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [CH_W-1:0]   wr_ch,
   input  logic [ADDR_W-1:0] mode_val,
   input  logic [ADDR_W-1:0] ext_val,
   output logic [NUM_CH-1:0] cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank,
   output logic              busy,
   output logic              done
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (BANK_W < 1) begin : g_bad_bank
      $error("BANK_W must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   logic              accept;
   logic [CH_W-1:0]   ch_q;
   logic [ADDR_W-1:0] mode_q;
   logic [ADDR_W-1:0] ext_q;
   logic [STEP_W-1:0] step;
   logic              issue;
   sdr_cmd_t          cmd;

   assign accept = wr_stb && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ch_q   <= '0;
         mode_q <= '0;
         ext_q  <= '0;
      end else if (accept) begin
         ch_q   <= wr_ch;
         mode_q <= mode_val;
         ext_q  <= ext_val;
      end
   end

   mrs_step_ctr u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_stb),
      .busy  (busy),
      .step  (step),
      .done  (done)
   );

   mrs_cmd_decode #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W)
   ) u_dec (
      .busy   (busy),
      .step   (step),
      .mode_q (mode_q),
      .ext_q  (ext_q),
      .issue  (issue),
      .cmd    (cmd),
      .addr   (addr),
      .bank   (bank)
   );

   mrs_cs_gen #(
      .NUM_CH       (NUM_CH),
      .CH_W         (CH_W),
      .SHIFT_DECODE (SHIFT_DECODE)
   ) u_cs (
      .issue (issue),
      .ch    (ch_q),
      .cs_n  (cs_n)
   );

   assign ras_n = cmd.ras_n;
   assign cas_n = cmd.cas_n;
   assign we_n  = cmd.we_n;

   // R1: idle outputs hold deselect and a zero bus
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ((&cs_n) && ras_n && cas_n && we_n && addr == '0 && bank == '0));

   // R2: an accepted write issues the base load with its own data
   p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (!ras_n && !cas_n && !we_n && bank == '0 && addr == $past(mode_val)));

   // R3: each load-mode command is followed by a deselect
   p_dsl_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |=> ((&cs_n) && ras_n && cas_n && we_n));

   // R5: at most one channel selected
   p_one_chan_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R5: a chip select only drops together with a command
   p_cs_with_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ras_n |-> (&cs_n));

   // R8: a strobe while busy leaves the latched target untouched
   p_hold_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_stb) |=> ($stable(ch_q) && $stable(mode_q) && $stable(ext_q)));

   // R6: the end of busy is always marked by done
   p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

// File: tb/mrs_seq_top_test.sv
`timescale 1ns/1ps
module mrs_seq_top_test;

   localparam int NUM_CH = 4;
   localparam int CH_W   = 2;
   localparam int ADDR_W = 13;
   localparam int BANK_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_stb = 1'b0;
   logic [CH_W-1:0]   wr_ch = '0;
   logic [ADDR_W-1:0] mode_val = '0;
   logic [ADDR_W-1:0] ext_val = '0;
   logic [NUM_CH-1:0] cs_n;
   logic              ras_n, cas_n, we_n;
   logic [ADDR_W-1:0] addr;
   logic [BANK_W-1:0] bank;
   logic              busy, done;

   int checks = 0;
   int fails  = 0;

   mrs_seq_top uut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_ch(wr_ch),
      .mode_val(mode_val), .ext_val(ext_val), .cs_n(cs_n),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
      .bank(bank), .busy(busy), .done(done)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [NUM_CH-1:0] exp_cs(input int ch, input bit sel);
      return sel ? ~(NUM_CH'(1) << ch) : {NUM_CH{1'b1}};
   endfunction

   function automatic logic [ADDR_W-1:0] exp_addr(input int k,
         input logic [ADDR_W-1:0] m, input logic [ADDR_W-1:0] e);
      if (k == 0) return m;
      if (k == 3) return e;
      return '0;
   endfunction

   task automatic drive(input bit stb, input int ch,
                        input logic [ADDR_W-1:0] m, input logic [ADDR_W-1:0] e);
      wr_stb   = stb;
      wr_ch    = CH_W'(ch);
      mode_val = m;
      ext_val  = e;
   endtask

   task automatic check_idle(input string req);
      chk(req, "idle busy", 32'(busy), 0);
      chk(req, "idle cs_n", 32'(cs_n), 32'(exp_cs(0, 1'b0)));
      chk(req, "idle cmd", 32'({ras_n, cas_n, we_n}), 7);
      chk(req, "idle addr", 32'(addr), 0);
      chk(req, "idle bank", 32'(bank), 0);
   endtask

   // Called at a negedge where the start strobe is already driven.
   task automatic run_seq(input int ch, input logic [ADDR_W-1:0] m,
                          input logic [ADDR_W-1:0] e, input bit noise,
                          input bit chain, input int nch,
                          input logic [ADDR_W-1:0] nm, input logic [ADDR_W-1:0] ne);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         begin
            bit    sel;
            string rq;
            sel = (k == 0) || (k == 3);
            rq  = (k == 0) ? "R2" : ((k == 3) ? "R4" : "R3");
            if (noise) rq = {rq, "/R8/R10"};
            chk(rq, "cs_n R5", 32'(cs_n), 32'(exp_cs(ch, sel)));
            chk(rq, "cmd", 32'({ras_n, cas_n, we_n}), sel ? 0 : 7);
            chk(rq, "addr", 32'(addr), 32'(exp_addr(k, m, e)));
            chk(rq, "bank", 32'(bank), (k == 3) ? 1 : 0);
            chk("R6", "busy", 32'(busy), 1);
            chk("R7", "done in run", 32'(done), 0);
         end
         if (noise)
            drive(1'($urandom), int'($urandom % NUM_CH),
                  ADDR_W'($urandom), ADDR_W'($urandom));
         else
            drive(1'b0, ch, m, e);
      end
      @(negedge clk);
      chk("R7", "done pulse", 32'(done), 1);
      check_idle("R1/R6");
      if (chain) drive(1'b1, nch, nm, ne);
      else       drive(1'b0, 0, '0, '0);
   endtask

   initial begin
      #(20 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int                cur_ch;
      logic [ADDR_W-1:0] cur_m, cur_e;
      bit                pending;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1");
      chk("R7", "reset done", 32'(done), 0);

      // Directed: base sequence on channel 0
      drive(1'b1, 0, 13'h0033, 13'h0040);
      run_seq(0, 13'h0033, 13'h0040, 1'b0, 1'b0, 0, '0, '0);
      @(negedge clk);
      chk("R7", "done single cycle", 32'(done), 0);
      check_idle("R1");

      // Directed: highest channel, all-ones data, strobes and data noise while busy
      drive(1'b1, NUM_CH - 1, '1, 13'h1555);
      run_seq(NUM_CH - 1, '1, 13'h1555, 1'b1, 1'b0, 0, '0, '0);
      @(negedge clk);
      check_idle("R8");

      // Directed: back-to-back via a strobe in the done cycle
      drive(1'b1, 1, 13'h0aaa, 13'h0001);
      run_seq(1, 13'h0aaa, 13'h0001, 1'b0, 1'b1, 2, 13'h0123, 13'h1abc);
      run_seq(2, 13'h0123, 13'h1abc, 1'b0, 1'b0, 0, '0, '0);  // R9

      // Random sequences
      pending = 1'b0;
      cur_ch  = int'($urandom % NUM_CH);
      cur_m   = ADDR_W'($urandom);
      cur_e   = ADDR_W'($urandom);
      for (int it = 0; it < 24; it++) begin
         bit                noise, chain;
         int                nch;
         logic [ADDR_W-1:0] nm, ne;
         noise = 1'($urandom);
         chain = (it != 23) && 1'($urandom);
         nch   = int'($urandom % NUM_CH);
         nm    = ADDR_W'($urandom);
         ne    = ADDR_W'($urandom);
         if (!pending) begin
            @(negedge clk);
            check_idle("R1");
            drive(1'b1, cur_ch, cur_m, cur_e);
         end
         run_seq(cur_ch, cur_m, cur_e, noise, chain, nch, nm, ne);
         cur_ch  = nch;
         cur_m   = nm;
         cur_e   = ne;
         pending = chain;
      end

      @(negedge clk);
      check_idle("R1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule